// File: doc/BRIEF.md
# SPI Byte-Memory Slave

This block is the serial front end of a byte-wide nonvolatile-style memory. A host drives a serial clock, an active-low select and a data line. The block decodes an 8-bit command and then moves data between the wire and an internal byte array or a small status register. Every write lands in the array while the byte is still on the bus, so there is never a busy state to poll. The host can start the next transaction as soon as the select has been released.

All serial pins are oversampled in the system clock domain through synchronizer chains. Clock polarity can therefore idle low (mode 0) or high (mode 3), and no logic is clocked by the serial clock itself. A write-enable latch guards every change to the array and to the status register. Only one command sets the latch. It drops by itself when a transaction that disables writes, writes the status register or writes memory ends.

The bus address is always 16 bits. The array size is set by `MEM_AW`: a full-size instance uses 16, which gives 65,536 bytes. A smaller default keeps elaboration light, and the upper address bits then alias.

Top module: `nvspi_mem_slave`

## Requirements
- R1: After reset the write-enable latch is 0, the status register reads 0x00 and `spi_dout_en` is low.
- R2: Command 0x06 sets the write-enable latch, and the latch reads back as status bit 1. The other command codes are 0x04 (disable writes), 0x05 (read status), 0x01 (write status), 0x03 (read memory) and 0x02 (write memory). Any other code is ignored until the select is released.
- R3: After command 0x04, the latch is 0 once the select returns high.
- R4: The select rising at the end of a status-write (0x01) or memory-write (0x02) transaction clears the latch.
- R5: Command 0x05 returns one status byte. Bit 1 holds the latch, bits 7, 3 and 2 hold stored flags, and bits 6:4 and bit 0 read 0. A status write stores bits 7, 3 and 2 only, and its bit 1 has no effect on the latch.
- R6: With the latch at 0, a status write or memory write is clocked in normally but changes neither the status register nor the array.
- R7: Memory commands send a 16-bit address, high byte first, and then data bytes. All bytes are most significant bit first. Read data returns exactly what an earlier write stored.
- R8: Within one memory transaction the address advances by one after each data byte and wraps from 0xFFFF to 0x0000.
- R9: If the select rises before all 8 bits of a byte have arrived, that byte is discarded and the array keeps its previous content.
- R10: Input bits are taken on the rising serial clock edge and output bits change on the falling edge, with the clock idling either low or high.
- R11: `spi_dout_en` is high only while status or read data is being shifted out. It is low during command, address and write phases and after the select is released.
- R12: A read may follow a write to the same address directly after the select is released, with no delay or polling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, runs at least 12 times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host (mode 0 or 3) |
| spi_sel_n | input | 1 | Active-low select |
| spi_din | input | 1 | Serial data from the host |
| spi_dout | output | 1 | Serial data to the host |
| spi_dout_en | output | 1 | Output enable for `spi_dout`; low means high impedance |

## Verification
Memory traffic uses single-byte and multi-byte bursts with patterns such as 0x01, 0x80, 0x5A and 0xC3, so a reversed bit order or an off-by-one bit shift gives a visibly wrong byte. A burst that starts at 0xFFFE shows whether the address counter wraps or stalls. The same bursts and status reads are repeated with the clock idling high and idling low, which tells sampling on the correct edge apart from sampling on the wrong one. Writes are issued with the latch set and with it cleared, and a byte cut off after four bits is followed by a read of the neighbouring address, so gated and discarded writes are told apart from applied ones.

// File: rtl/nvspi_pkg.sv
package nvspi_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_RDATA,
    ST_WDATA,
    ST_SR_RD,
    ST_SR_WR,
    ST_SKIP
  } nv_state_e;

  // Commands whose completion drops the write-enable latch.
  function automatic logic drops_latch(input logic [7:0] op);
    return (op == OP_WRDI) || (op == OP_WRSR) || (op == OP_WRIT);
  endfunction

endpackage

// File: rtl/nvspi_pin_sync.sv
module nvspi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic sel_n_in,
  input  logic din_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_start,
  output logic sel_end,
  output logic sel_active,
  output logic din_s
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sck_sh, sel_sh, din_sh;
  logic              sck_d, sel_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sh <= '0;
      sel_sh <= '1;
      din_sh <= '0;
      sck_d  <= 1'b0;
      sel_d  <= 1'b1;
    end else begin
      sck_sh <= {sck_sh[LAST-1:0], sck_in};
      sel_sh <= {sel_sh[LAST-1:0], sel_n_in};
      din_sh <= {din_sh[LAST-1:0], din_in};
      sck_d  <= sck_sh[LAST];
      sel_d  <= sel_sh[LAST];
    end
  end

  assign sck_rise   =  sck_sh[LAST] & ~sck_d;
  assign sck_fall   = ~sck_sh[LAST] &  sck_d;
  assign sel_start  = ~sel_sh[LAST] &  sel_d;
  assign sel_end    =  sel_sh[LAST] & ~sel_d;
  assign sel_active = ~sel_sh[LAST];
  assign din_s      =  din_sh[LAST];

endmodule

// File: rtl/nvspi_byte_rx.sv
module nvspi_byte_rx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            active,
  input  logic            rise,
  input  logic            din,
  output logic [BITS-1:0] rx_byte,
  output logic            byte_done,
  output logic [$clog2(BITS)-1:0] bit_cnt
);

  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

  logic [BITS-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      bit_cnt   <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start || !active) begin
        bit_cnt <= '0;
      end else if (rise) begin
        sh_q    <= {sh_q[BITS-3:0], din};
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          rx_byte   <= {sh_q, din};
          byte_done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/nvspi_mem.sv
module nvspi_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          re,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[wr_addr] <= wr_data;
    if (re) rd_data <= ram[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= re;
  end

endmodule

// File: rtl/nvspi_mem_slave.sv
module nvspi_mem_slave
  import nvspi_pkg::*;
#(
  parameter int         MEM_AW    = 10,
  parameter int         SYNC_STG  = 2,
  parameter logic [7:0] SR_WMASK  = 8'h8C
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_sel_n,
  input  logic spi_din,
  output logic spi_dout,
  output logic spi_dout_en
);

  localparam int         BUS_AW  = 16;
  localparam logic [7:0] SR_KEEP = SR_WMASK & 8'hFC;

  logic       sck_rise, sck_fall, sel_start, sel_end, sel_active, din_s;
  logic [7:0] rx_byte;
  logic       byte_done;
  logic [2:0] bit_cnt;

  nv_state_e         state_q;
  logic [7:0]        cmd_q;
  logic              wel_q;
  logic [7:0]        sr_bits_q;
  logic [BUS_AW-1:0] addr_q;
  logic [7:0]        tx_byte_q;
  logic [7:0]        status_w;

  logic              rd_en, mem_we, rd_valid;
  logic [BUS_AW-1:0] rd_addr;
  logic [7:0]        rd_data;

  nvspi_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sck_in    (spi_sck),
    .sel_n_in  (spi_sel_n),
    .din_in    (spi_din),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sel_start (sel_start),
    .sel_end   (sel_end),
    .sel_active(sel_active),
    .din_s     (din_s)
  );

  nvspi_byte_rx #(.BITS(8)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .start    (sel_start),
    .active   (sel_active),
    .rise     (sck_rise),
    .din      (din_s),
    .rx_byte  (rx_byte),
    .byte_done(byte_done),
    .bit_cnt  (bit_cnt)
  );

  nvspi_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .we      (mem_we),
    .wr_addr (addr_q[MEM_AW-1:0]),
    .wr_data (rx_byte),
    .re      (rd_en),
    .rd_addr (rd_addr[MEM_AW-1:0]),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  assign status_w = sr_bits_q | {6'b0, wel_q, 1'b0};

  // Array port requests, issued in the cycle a byte completes.
  always_comb begin
    rd_en   = 1'b0;
    rd_addr = addr_q;
    if (sel_active && byte_done) begin
      if (state_q == ST_ADDR_LO && cmd_q == OP_READ) begin
        rd_en   = 1'b1;
        rd_addr = {addr_q[15:8], rx_byte};
      end else if (state_q == ST_RDATA) begin
        rd_en = 1'b1;
      end
    end
    mem_we = sel_active && byte_done && (state_q == ST_WDATA) && wel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cmd_q       <= 8'h00;
      wel_q       <= 1'b0;
      sr_bits_q   <= 8'h00;
      addr_q      <= '0;
      tx_byte_q   <= 8'h00;
      spi_dout    <= 1'b0;
      spi_dout_en <= 1'b0;
    end else begin
      if (rd_valid) tx_byte_q <= rd_data;

      if (sel_start) begin
        state_q <= ST_OPC;
        cmd_q   <= 8'h00;
      end else if (sel_end) begin
        state_q     <= ST_IDLE;
        spi_dout_en <= 1'b0;
        if (drops_latch(cmd_q)) wel_q <= 1'b0;
      end else if (sel_active) begin
        if (byte_done) begin
          unique case (state_q)
            ST_OPC: begin
              cmd_q <= rx_byte;
              case (rx_byte)
                OP_WREN: begin wel_q <= 1'b1; state_q <= ST_SKIP; end
                OP_RDSR: begin tx_byte_q <= status_w; state_q <= ST_SR_RD; end
                OP_WRSR: state_q <= ST_SR_WR;
                OP_READ, OP_WRIT: state_q <= ST_ADDR_HI;
                default: state_q <= ST_SKIP;
              endcase
            end
            ST_ADDR_HI: begin
              addr_q[15:8] <= rx_byte;
              state_q      <= ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
              if (cmd_q == OP_READ) begin
                addr_q  <= {addr_q[15:8], rx_byte} + 16'd1;
                state_q <= ST_RDATA;
              end else begin
                addr_q  <= {addr_q[15:8], rx_byte};
                state_q <= ST_WDATA;
              end
            end
            ST_RDATA, ST_WDATA: addr_q <= addr_q + 16'd1;
            ST_SR_WR: begin
              if (wel_q) sr_bits_q <= rx_byte & SR_KEEP;
              state_q <= ST_SKIP;
            end
            ST_SR_RD: state_q <= ST_SKIP;
            default: ;
          endcase
        end

        if (sck_fall) begin
          if (state_q == ST_RDATA || state_q == ST_SR_RD) begin
            spi_dout    <= tx_byte_q[~bit_cnt];
            spi_dout_en <= 1'b1;
          end else begin
            spi_dout_en <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/nvspi_mem_slave_chk.sv
module nvspi_mem_slave_chk
  import nvspi_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sel_active,
  input logic       sel_end,
  input logic       byte_done,
  input logic [7:0] rx_byte,
  input logic       wel,
  input logic [7:0] sr_bits,
  input logic [15:0] addr,
  input nv_state_e  state,
  input logic       dout_en
);

  assert_wel_reset_R1: assert property (@(posedge clk)
    rst |=> !wel);

  assert_wel_set_only_by_wren_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(wel) && wel) |-> ($past(byte_done) && $past(rx_byte) == OP_WREN));

  assert_wel_drop_at_deselect_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(wel) |-> $past(sel_end));

  assert_status_gated_R6: assert property (@(posedge clk) disable iff (rst)
    (sr_bits != $past(sr_bits)) |-> $past(wel));

  assert_addr_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (sel_active && byte_done && state == ST_RDATA) |=> (addr == $past(addr) + 16'd1));

  assert_hiz_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !sel_active |=> !dout_en);

endmodule

bind nvspi_mem_slave nvspi_mem_slave_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .sel_active(sel_active),
  .sel_end   (sel_end),
  .byte_done (byte_done),
  .rx_byte   (rx_byte),
  .wel       (wel_q),
  .sr_bits   (sr_bits_q),
  .addr      (addr_q),
  .state     (state_q),
  .dout_en   (spi_dout_en)
);

// File: tb/nvspi_mem_slave_tb.sv
module nvspi_mem_slave_tb_top;

  localparam int HALF = 8;

  typedef logic [7:0] bq_t [$];
  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_sel_n = 1'b1;
  logic spi_din = 1'b0;
  logic spi_dout, spi_dout_en;

  int   checks = 0;
  int   errors = 0;
  bit   mode3 = 1'b0;
  bit   mon_on = 1'b0;
  int   mon_n = 0;
  logic [7:0] mon_sh = 8'h00;
  exp_t exp_q [$];

  nvspi_mem_slave dut_i (
    .clk        (clk),
    .rst        (rst),
    .spi_sck    (spi_sck),
    .spi_sel_n  (spi_sel_n),
    .spi_din    (spi_din),
    .spi_dout   (spi_dout),
    .spi_dout_en(spi_dout_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Monitor: collects bits on each host sampling edge and scores each byte.
  always @(posedge spi_sck) begin
    if (mon_on) begin
      if (mon_n == 0) chk("R11 enable during read", {7'b0, spi_dout_en}, 8'h01);
      mon_sh = {mon_sh[6:0], spi_dout};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R7: actual=%02h expected=none (unexpected byte)", mon_sh);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, mon_sh, e.val);
        end
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer();
    spi_sck = mode3;
    wclk(2);
    spi_sel_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_sck = 1'b0;
      spi_din = b[i];
      wclk(HALF);
      spi_sck = 1'b1;
      wclk(HALF);
    end
  endtask

  task automatic end_xfer();
    if (!mode3) begin
      spi_sck = 1'b0;
      wclk(HALF);
    end
    spi_sel_n = 1'b1;
    wclk(3 * HALF);
  endtask

  task automatic cmd_only(input logic [7:0] op);
    begin_xfer();
    send_bits(op, 8);
    end_xfer();
  endtask

  task automatic rdsr(input logic [7:0] exp, input string req);
    exp_t e;
    begin_xfer();
    send_bits(8'h05, 8);
    e.val = exp;
    e.req = req;
    exp_q.push_back(e);
    mon_on = 1'b1;
    send_bits(8'h00, 8);
    mon_on = 1'b0;
    end_xfer();
    chk("R11 released after status", {7'b0, spi_dout_en}, 8'h00);
  endtask

  task automatic wrsr(input logic [7:0] v);
    begin_xfer();
    send_bits(8'h01, 8);
    send_bits(v, 8);
    end_xfer();
  endtask

  task automatic mem_write(input logic [15:0] a, input bq_t d);
    begin_xfer();
    send_bits(8'h02, 8);
    send_bits(a[15:8], 8);
    send_bits(a[7:0], 8);
    foreach (d[i]) send_bits(d[i], 8);
    chk("R11 no drive in write phase", {7'b0, spi_dout_en}, 8'h00);
    end_xfer();
  endtask

  task automatic mem_read(input logic [15:0] a, input bq_t d, input string req);
    begin_xfer();
    send_bits(8'h03, 8);
    send_bits(a[15:8], 8);
    send_bits(a[7:0], 8);
    foreach (d[i]) begin
      exp_t e;
      e.val = d[i];
      e.req = req;
      exp_q.push_back(e);
    end
    mon_on = 1'b1;
    foreach (d[i]) send_bits(8'h00, 8);
    mon_on = 1'b0;
    end_xfer();
    chk("R11 released after read", {7'b0, spi_dout_en}, 8'h00);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    wclk(6);
    rst = 1'b0;
    wclk(4);
    // R1: reset state
    chk("R1 enable after reset", {7'b0, spi_dout_en}, 8'h00);
    rdsr(8'h00, "R1 status after reset");

    // R2: latch set, visible at bit 1; R7 basic write
    cmd_only(8'h06);
    rdsr(8'h02, "R2 latch set by 0x06");
    mem_write(16'h0010, '{8'h11});
    rdsr(8'h00, "R4 latch cleared after memory write");
    // R6: write without latch is ignored
    mem_write(16'h0010, '{8'hA5});
    mem_read(16'h0010, '{8'h11}, "R6 gated memory write");

    // R5/R4: status write stores bits 7,3,2 only and drops latch
    cmd_only(8'h06);
    wrsr(8'hFF);
    rdsr(8'h8C, "R5 status mask and R4 latch drop");
    wrsr(8'h00);
    rdsr(8'h8C, "R6 gated status write");
    cmd_only(8'h06);
    rdsr(8'h8E, "R5 latch bit with stored flags");
    cmd_only(8'h04);
    rdsr(8'h8C, "R3 latch cleared by 0x04");
    cmd_only(8'h06);
    wrsr(8'h06);
    rdsr(8'h04, "R5 bit 1 of status data ignored");
    // R2: unknown opcode leaves latch alone
    cmd_only(8'h06);
    cmd_only(8'hB7);
    rdsr(8'h06, "R2 unknown code ignored");
    wrsr(8'h00);

    // R7/R8/R10: bursts in mode 3 then mode 0
    mode3 = 1'b1;
    rdsr(8'h00, "R10 status read in mode 3");
    cmd_only(8'h06);
    mem_write(16'h0100, '{8'h01, 8'h80, 8'h5A, 8'hC3});
    mem_read(16'h0100, '{8'h01, 8'h80, 8'h5A, 8'hC3}, "R10 burst read in mode 3");
    mode3 = 1'b0;
    mem_read(16'h0101, '{8'h80, 8'h5A}, "R8 burst offset read in mode 0");
    cmd_only(8'h06);
    mem_write(16'h0102, '{8'h3E});
    mem_read(16'h0100, '{8'h01, 8'h80, 8'h3E, 8'hC3}, "R7 overwrite in mode 0");

    // R8: wrap from 0xFFFF to 0x0000
    cmd_only(8'h06);
    mem_write(16'hFFFE, '{8'hDE, 8'hAD, 8'hBE});
    mem_read(16'hFFFF, '{8'hAD, 8'hBE}, "R8 read wrap");
    mem_read(16'h0000, '{8'hBE}, "R8 write wrap");

    // R9: truncated byte discarded
    cmd_only(8'h06);
    mem_write(16'h0201, '{8'h99});
    cmd_only(8'h06);
    begin_xfer();
    send_bits(8'h02, 8);
    send_bits(8'h02, 8);
    send_bits(8'h00, 8);
    send_bits(8'h77, 8);
    send_bits(8'h33, 4);
    end_xfer();
    mem_read(16'h0200, '{8'h77, 8'h99}, "R9 partial byte discarded");
    rdsr(8'h00, "R4 latch cleared after cut write");

    // R12: read straight after write
    cmd_only(8'h06);
    mem_write(16'h0300, '{8'h3C});
    mem_read(16'h0300, '{8'h3C}, "R12 back-to-back read");

    chk("R7 all expected bytes seen", 8'(exp_q.size()), 8'h00);
    summary();
    $finish;
  end

endmodule